// File: doc/BRIEF.md
# Region Cache Policy Demotion Register

This block keeps a two-bit cache policy for each of sixteen equal slices of the address map. A cache front end presents an address on the lookup port and, one clock later, receives the policy of the slice that address falls in: non-cacheable, write-through or write-back. After reset every slice holds write-back, the strongest policy.

Software may only weaken a slice's policy at run time. A demotion request carries a slice index and a new policy code, and one clock later the block answers with a single-cycle response marked accepted or refused. Any request that would keep or raise the policy, or that uses the reserved code, is refused and changes nothing. An accepted request does not take effect at once. The block first asks an external maintenance engine for a full cache clear (dirty lines pushed, then all lines invalidated). It writes the new policy only when that engine reports completion. Until then, lookups keep returning the old policy and any further request is refused. Only reset raises a policy again.

Top module: `region_policy_guard`

## Requirements
- R1: While reset is high and on the first cycles after it, `lk_mode` reads 3 (write-back) for every slice, and `resp_valid` and `clr_req` are low.
- R2: The slice of a lookup is given by the top four bits of `lk_addr`. The lower bits have no effect. `lk_mode` shows the policy of the slice presented on the previous clock edge.
- R3: Request index i selects slice 15 − i (index 0 is slice 15, index 15 is slice 0). Every request sampled with `req_valid` high produces exactly one `resp_valid` pulse on the next cycle.
- R4: A request is accepted (`resp_ok` = 1) when no clear is pending, its code is not 1, and its code is strictly lower than the selected slice's current policy. Policy codes: 0 non-cacheable, 2 write-through, 3 write-back.
- R5: A request whose code is greater than or equal to the current policy is refused (`resp_ok` = 0). No clear is started and no slice's policy changes.
- R6: A request carrying the reserved code 1 is refused and changes nothing. No slice ever reads 1.
- R7: After an accepted request, `clr_req` rises in the same cycle as the response and stays high until `clr_done` is seen. Meanwhile lookups return the old policy.
- R8: The clock edge that samples `clr_done` high while `clr_req` is high writes the new policy and drops `clr_req`. The next lookup shows the new policy.
- R9: Any request arriving while a clear is pending is refused and leaves every slice unchanged.
- R10: Asserting reset after demotions restores write-back in every slice and cancels any pending clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Lookup address |
| lk_mode | output | 2 | Registered policy of the slice looked up on the previous edge |
| req_valid | input | 1 | Demotion request strobe |
| req_idx | input | 4 | Request index (inverted slice number) |
| req_mode | input | 2 | Requested new policy code |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ok | output | 1 | 1 = accepted, 0 = refused; valid with resp_valid |
| clr_req | output | 1 | Full cache clear requested; held until clr_done |
| clr_done | input | 1 | Clear completion pulse from the maintenance engine |

## Verification
A corrupted policy entry reaches `lk_mode` on the first lookup of that slice after the bad edge. Through the accept rule it also shows in the verdict of the next request to that slice. A wrong index inversion shows up as the wrong slice changing, which a lookup of both the intended and the mirrored slice reveals at once. A lost or premature commit shows in `clr_req` and in lookups made during the pending window, one cycle after the edge that was wrong.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  typedef enum logic [1:0] {
    CM_NONCACHE = 2'd0,
    CM_RSVD     = 2'd1,
    CM_WTHRU    = 2'd2,
    CM_WBACK    = 2'd3
  } cmode_e;

  localparam logic [1:0] CM_TOP = 2'(CM_WBACK);
  localparam logic [1:0] CM_BAD = 2'(CM_RSVD);
endpackage

// File: rtl/mode_table.sv
module mode_table
  import rcm_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_mode,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [1:0]       rd_mode_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [1:0]       rd_mode_b
);
  logic [1:0] tbl [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        tbl[g] <= CM_TOP;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        tbl[g] <= wr_mode;
    end

    // R6: reserved code never stored
    p_entry_legal_r6: assert property (@(posedge clk) disable iff (rst)
      tbl[g] != CM_BAD);
    // R5: a slot only moves downward
    p_only_lower_r5: assert property (@(posedge clk) disable iff (rst)
      !$stable(tbl[g]) |-> (tbl[g] < $past(tbl[g])));
    // R8: a slot changes only on a commit strobe
    p_write_on_commit_r8: assert property (@(posedge clk) disable iff (rst)
      !$stable(tbl[g]) |-> $past(wr_en));
  end

  assign rd_mode_a = tbl[rd_idx_a];
  assign rd_mode_b = tbl[rd_idx_b];
endmodule

// File: rtl/region_lookup.sv
module region_lookup
  import rcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  slot_idx,
  input  logic [1:0]        slot_mode,
  output logic [1:0]        lk_mode
);
  assign slot_idx = addr[ADDR_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (rst) lk_mode <= CM_TOP;
    else     lk_mode <= slot_mode;
  end

  // R2/R6: registered lookup never shows the reserved code
  p_lookup_legal_r2: assert property (@(posedge clk) disable iff (rst)
    lk_mode != CM_BAD);
endmodule

// File: rtl/demote_ctrl.sv
module demote_ctrl
  import rcm_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [1:0]       req_mode,
  output logic [IDX_W-1:0] tgt_idx,
  input  logic [1:0]       cur_mode,
  output logic             resp_valid,
  output logic             resp_ok,
  output logic             clr_req,
  input  logic             clr_done,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [1:0]       wr_mode
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

  logic             pending;
  logic [IDX_W-1:0] pend_idx;
  logic [1:0]       pend_mode;
  logic             code_ok, lowers, accept, commit;

  assign tgt_idx = LAST - req_idx;
  assign code_ok = (req_mode != CM_BAD);
  assign lowers  = (req_mode < cur_mode);
  assign accept  = req_valid && !pending && code_ok && lowers;
  assign commit  = pending && clr_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      pend_idx   <= '0;
      pend_mode  <= CM_TOP;
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_ok    <= accept;
      if (accept) begin
        pending   <= 1'b1;
        pend_idx  <= tgt_idx;
        pend_mode <= req_mode;
      end else if (commit) begin
        pending <= 1'b0;
      end
    end
  end

  assign clr_req = pending;
  assign wr_en   = commit;
  assign wr_idx  = pend_idx;
  assign wr_mode = pend_mode;

  // R3: a response only follows a request
  p_resp_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid));
  // R4: an accepted response comes with a clear request
  p_accept_starts_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_ok) |-> clr_req);
  // R7: clear request held until completion is seen
  p_clr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !clr_done) |=> clr_req);
  // R9: requests during a pending clear are refused
  p_busy_reject_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && clr_req) |=> (resp_valid && !resp_ok));
endmodule

// File: rtl/region_policy_guard.sv
module region_policy_guard
  import rcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [1:0]        lk_mode,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [1:0]        req_mode,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic              clr_req,
  input  logic              clr_done
);
  logic [IDX_W-1:0] a_idx, b_idx, w_idx;
  logic [1:0]       a_mode, b_mode, w_mode;
  logic             w_en;

  region_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_look (
    .clk(clk), .rst(rst), .addr(lk_addr), .slot_idx(a_idx),
    .slot_mode(a_mode), .lk_mode(lk_mode)
  );

  demote_ctrl #(.NREG(NREG), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_idx(req_idx),
    .req_mode(req_mode), .tgt_idx(b_idx), .cur_mode(b_mode),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .clr_req(clr_req),
    .clr_done(clr_done), .wr_en(w_en), .wr_idx(w_idx), .wr_mode(w_mode)
  );

  mode_table #(.NREG(NREG), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(w_en), .wr_idx(w_idx), .wr_mode(w_mode),
    .rd_idx_a(a_idx), .rd_mode_a(a_mode), .rd_idx_b(b_idx), .rd_mode_b(b_mode)
  );
endmodule

// File: tb/sim_region_policy_guard.sv
`timescale 1ns/1ps
module sim_region_policy_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_mode;
  logic        req_valid = 1'b0;
  logic [3:0]  req_idx = '0;
  logic [1:0]  req_mode = '0;
  logic        resp_valid, resp_ok, clr_req;
  logic        clr_done = 1'b0;

  always #2.5 clk = ~clk;

  region_policy_guard u0 (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_mode(lk_mode),
    .req_valid(req_valid), .req_idx(req_idx), .req_mode(req_mode),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .clr_req(clr_req),
    .clr_done(clr_done)
  );

  int n_chk = 0, n_fail = 0;
  logic  exp_q[$];
  string tag_q[$];
  logic [1:0] model [16];
  bit         mpend;
  int         pend_r;
  logic [1:0] pend_m;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected response", 1, 0);
      else begin
        automatic logic  e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(resp_ok == e, t, int'(resp_ok), int'(e));
      end
    end
  end

  function automatic logic [31:0] addr_of(input int r, input logic [27:0] low);
    return {4'(r), low};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b0 && clr_req == 1'b0, "R1 outputs low in reset",
          int'({resp_valid, clr_req}), 0);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 2'd3;
    mpend = 1'b0;
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic do_req(input int idx, input logic [1:0] m, input string tag);
    automatic int   r  = 15 - idx;
    automatic logic ok = !mpend && (m != 2'd1) && (m < model[r]);
    exp_q.push_back(ok); tag_q.push_back(tag);
    if (ok) begin mpend = 1'b1; pend_r = r; pend_m = m; end
    req_valid = 1'b1; req_idx = 4'(idx); req_mode = m;
    @(negedge clk);
    req_valid = 1'b0;
    check(clr_req == mpend, {tag, " clr_req"}, int'(clr_req), int'(mpend));
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] e, input string tag);
    lk_addr = a;
    @(negedge clk);
    check(lk_mode == e, tag, int'(lk_mode), int'(e));
  endtask

  task automatic finish_clear();
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    model[pend_r] = pend_m; mpend = 1'b0;
    check(clr_req == 1'b0, "R8 clr_req drops on done", int'(clr_req), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int r = 0; r < 16; r += 5) look(addr_of(r, 28'h0), 2'd3, "R1 reset mode write-back");

    do_req(0, 2'd3, "R5 equal mode refused");
    do_req(0, 2'd1, "R6 reserved code refused");
    look(addr_of(15, 28'h1234), 2'd3, "R6 slice unchanged after refusal");

    do_req(0, 2'd2, "R4 WB to WT accepted");
    check(clr_req == 1'b1, "R7 clear requested", int'(clr_req), 1);
    look(addr_of(15, 28'h0), 2'd3, "R7 old mode while pending");
    do_req(5, 2'd0, "R9 request while pending refused");
    repeat (3) @(negedge clk);
    check(clr_req == 1'b1, "R7 clear held until done", int'(clr_req), 1);
    look(addr_of(10, 28'h0), 2'd3, "R9 refused slice unchanged");
    finish_clear();
    look(addr_of(15, 28'hFFF_FFFF), 2'd2, "R8 new mode after commit");
    look(addr_of(0, 28'h0), 2'd3, "R3 mirrored slice untouched");

    do_req(0, 2'd2, "R5 same mode refused");
    do_req(0, 2'd3, "R5 promotion refused");
    do_req(0, 2'd0, "R4 WT to NC accepted");
    finish_clear();
    look(addr_of(15, 28'h0), 2'd0, "R8 non-cacheable committed");
    do_req(0, 2'd0, "R5 NC to NC refused");

    do_req(15, 2'd0, "R4 WB to NC direct, index 15");
    finish_clear();
    look(addr_of(0, 28'hFFF_FFFF), 2'd0, "R3 index 15 is slice 0");
    look(addr_of(1, 28'h0), 2'd3, "R2 neighbouring slice write-back");
    look(addr_of(15, 28'hABC_DEF0), 2'd0, "R2 low bits ignored");

    do_req(7, 2'd2, "R4 slice 8 accepted");
    do_reset();
    look(addr_of(8, 28'h0), 2'd3, "R10 pending cancelled by reset");
    look(addr_of(15, 28'h0), 2'd3, "R10 reset restores write-back");
    look(addr_of(0, 28'h0), 2'd3, "R10 reset restores slice 0");
    check(clr_req == 1'b0, "R10 no clear after reset", int'(clr_req), 0);
    do_req(7, 2'd2, "R10 demotion allowed again");
    finish_clear();
    look(addr_of(8, 28'h0), 2'd2, "R8 slice 8 write-through");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3 every request answered", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule